// File: doc/BRIEF.md
# Two-port read-to-acquire lock

A single-bit hardware lock that lets independent processors share one peripheral without a software handshake. Each processor has its own register port. A read of the lock register acts as test-and-set: it returns the lock's prior state in bit 0 and, if the lock was free, takes it in the same access. Any later read returns busy until some port writes 1 to bit 0, which frees the lock.

The lock has no notion of an owner. A processor that read 0 holds the lock by convention and is expected to release it. Accesses from several ports in one cycle are resolved in a fixed order: releases take effect first, then the lowest-numbered reader gets the lock. Read data is combinational and is valid in the same cycle as the access. The lock changes state at the clock edge that ends that cycle.

Top module: `hw_sema_lock`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the lock is free, so the first read of the lock register returns 0 in bit 0.
- R2: A read of the lock register (req=1, we=0, addr=LOCK_OFS) while the lock is free returns 0 in bit 0 in that cycle and leaves the lock held after the clock edge.
- R3: A read of the lock register while the lock is held returns 1 in bit 0, and the lock stays held.
- R4: A write to the lock register with bit 0 of the write data at 1 frees the lock at the clock edge.
- R5: A write to the lock register with bit 0 of the write data at 0 leaves the lock unchanged, whatever the upper data bits are.
- R6: When several ports read the lock register in the same cycle while it is free, the lowest-numbered port reads 0 and every other reader reads 1. The lock is held afterwards.
- R7: A release and a read in the same cycle are ordered release first: the reader sees 0 and the lock is held afterwards.
- R8: An access to any address other than LOCK_OFS leaves the lock unchanged and returns all-zero read data.
- R9: Read data bits above bit 0 are always 0, and read data is all-zero on a port that is not reading the lock register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_PORTS | Per-port access strobe |
| we_i | input | N_PORTS | Per-port write enable (1 = write, 0 = read) |
| addr_i | input | N_PORTS*ADDR_W | Per-port register address, port k at bits [k*ADDR_W +: ADDR_W] |
| wdata_i | input | N_PORTS*DATA_W | Per-port write data, port k at bits [k*DATA_W +: DATA_W] |
| rdata_o | output | N_PORTS*DATA_W | Per-port combinational read data, same slicing as wdata_i |

## Verification
The bench builds the block with its defaults: two ports, 8-bit data, 4-bit address and the lock at offset 8. With two ports and six access kinds per port (idle, lock read, release, zero-bit write, foreign-address read, foreign-address write), all 36 pairings can be applied from both starting states of the lock. This covers every same-cycle collision, including read against read and release against read. After each pairing a probe read shows the resulting lock state at the port.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int unsigned DEF_PORTS  = 2;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_ADDR_W = 4;
  localparam int unsigned DEF_LOCK_OFS = 8;

  typedef enum logic {
    LOCK_FREE = 1'b0,
    LOCK_HELD = 1'b1
  } lock_state_e;
endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
  parameter int unsigned ADDR_W   = sema_pkg::DEF_ADDR_W,
  parameter int unsigned LOCK_OFS = sema_pkg::DEF_LOCK_OFS
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbit0_i,
  output logic              rd_hit_o,
  output logic              rel_hit_o
);
  localparam logic [ADDR_W-1:0] LockAddr = ADDR_W'(LOCK_OFS);

  logic sel;
  assign sel       = req_i && (addr_i == LockAddr);
  assign rd_hit_o  = sel && !we_i;
  assign rel_hit_o = sel && we_i && wbit0_i;
endmodule

// File: rtl/sema_core.sv
module sema_core
  import sema_pkg::*;
#(
  parameter int unsigned N_PORTS = DEF_PORTS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] rd_hit_i,
  input  logic [N_PORTS-1:0] rel_hit_i,
  output logic [N_PORTS-1:0] grant_o
);
  lock_state_e lock_q, lock_d;
  logic        free_eff;
  logic        rel_any;
  logic        rd_any;

  assign rel_any  = |rel_hit_i;
  assign rd_any   = |rd_hit_i;
  // release is ordered ahead of reads in the same cycle
  assign free_eff = (lock_q == LOCK_FREE) || rel_any;

  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int k = 0; k < N_PORTS; k++) begin
      grant_o[k] = rd_hit_i[k] && free_eff && !taken;
      taken      = taken || grant_o[k];
    end
  end

  always_comb begin
    lock_d = lock_q;
    if (|grant_o)    lock_d = LOCK_HELD;
    else if (rel_any) lock_d = LOCK_FREE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= LOCK_FREE;
    else         lock_q <= lock_d;
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  // R2
  grant_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |=> (lock_q == LOCK_HELD));
  // R3
  held_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lock_q == LOCK_HELD) && !rel_any) |-> (grant_o == '0));
  // R7
  release_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_any && rd_any) |=> (lock_q == LOCK_HELD));
  // R4
  release_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_any && !rd_any) |=> (lock_q == LOCK_FREE));
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rel_any && !rd_any) |=> $stable(lock_q));
endmodule

// File: rtl/hw_sema_lock.sv
module hw_sema_lock
  import sema_pkg::*;
#(
  parameter int unsigned N_PORTS  = DEF_PORTS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned LOCK_OFS = DEF_LOCK_OFS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PORTS-1:0]        req_i,
  input  logic [N_PORTS-1:0]        we_i,
  input  logic [N_PORTS*ADDR_W-1:0] addr_i,
  input  logic [N_PORTS*DATA_W-1:0] wdata_i,
  output logic [N_PORTS*DATA_W-1:0] rdata_o
);
  logic [N_PORTS-1:0] rd_hit;
  logic [N_PORTS-1:0] rel_hit;
  logic [N_PORTS-1:0] grant;

  for (genvar k = 0; k < N_PORTS; k++) begin : g_port
    sema_port_dec #(
      .ADDR_W  (ADDR_W),
      .LOCK_OFS(LOCK_OFS)
    ) u_dec (
      .req_i    (req_i[k]),
      .we_i     (we_i[k]),
      .addr_i   (addr_i[k*ADDR_W +: ADDR_W]),
      .wbit0_i  (wdata_i[k*DATA_W]),
      .rd_hit_o (rd_hit[k]),
      .rel_hit_o(rel_hit[k])
    );

    // bit 0 reports busy: a lock read that did not win
    assign rdata_o[k*DATA_W +: DATA_W] =
      {{(DATA_W-1){1'b0}}, rd_hit[k] && !grant[k]};
  end

  sema_core #(
    .N_PORTS(N_PORTS)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_hit_i (rd_hit),
    .rel_hit_i(rel_hit),
    .grant_o  (grant)
  );
endmodule

// File: tb/hw_sema_lock_bench.sv
module hw_sema_lock_bench;
  localparam int NP = 2;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam logic [AW-1:0] LOCK_A  = 4'h8;
  localparam logic [AW-1:0] OTHER_A = 4'h9;

  // access kinds
  localparam int OP_IDLE = 0, OP_RD = 1, OP_W1 = 2, OP_W0 = 3, OP_RDX = 4, OP_WX = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NP-1:0]     req_i = '0;
  logic [NP-1:0]     we_i = '0;
  logic [NP*AW-1:0]  addr_i = '0;
  logic [NP*DW-1:0]  wdata_i = '0;
  logic [NP*DW-1:0]  rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  hw_sema_lock u_hw_sema_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  task automatic set_port(input int p, input int op);
    req_i[p] = (op != OP_IDLE);
    we_i[p]  = (op == OP_W1) || (op == OP_W0) || (op == OP_WX);
    addr_i[p*AW +: AW] = (op == OP_RDX || op == OP_WX) ? OTHER_A : LOCK_A;
    wdata_i[p*DW +: DW] = (op == OP_W0) ? 8'hFE : 8'hFF;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // drive on negedge, sample 2 ns later, then let the edge pass
  task automatic cycle(input int op0, input int op1);
    @(negedge clk_i);
    set_port(0, op0);
    set_port(1, op1);
    #2;
  endtask

  task automatic idle_all();
    @(negedge clk_i);
    set_port(0, OP_IDLE);
    set_port(1, OP_IDLE);
  endtask

  function automatic string tag_of(int op0, int op1, bit s);
    bit rel = (op0 == OP_W1) || (op1 == OP_W1);
    if (op0 == OP_RD && op1 == OP_RD && !s) return "R6";
    if (rel && (op0 == OP_RD || op1 == OP_RD)) return "R7";
    if (op0 == OP_RDX || op1 == OP_RDX || op0 == OP_WX || op1 == OP_WX) return "R8";
    if (op0 == OP_W0 || op1 == OP_W0) return "R5";
    if (rel) return "R4";
    if (s) return "R3";
    return "R2";
  endfunction

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: first read after reset sees free
    cycle(OP_RD, OP_IDLE);
    check("R1", rdata_o[0 +: DW], 8'h00);
    check("R9", rdata_o[DW +: DW], 8'h00);
    // start from free
    cycle(OP_W1, OP_IDLE);

    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 6; a++) begin
        for (int b = 0; b < 6; b++) begin
          bit rel, free, t0, nxt;
          logic [DW-1:0] e0, e1;
          string tg;
          // establish lock state s
          cycle(OP_W1, OP_IDLE);
          if (s == 1) cycle(OP_RD, OP_IDLE);
          rel  = (a == OP_W1) || (b == OP_W1);
          free = (s == 0) || rel;
          t0   = (a == OP_RD) && free;
          e0 = (a == OP_RD) ? {7'd0, !free} : 8'h00;
          e1 = (b == OP_RD) ? {7'd0, !(free && !t0)} : 8'h00;
          if (((a == OP_RD) || (b == OP_RD)) && free) nxt = 1'b1;
          else if (rel) nxt = 1'b0;
          else nxt = s[0];
          tg = tag_of(a, b, s[0]);
          cycle(a, b);
          check(tg, rdata_o[0 +: DW], e0);
          check((e1 == 8'h00 && b != OP_RD) ? "R9" : tg, rdata_o[DW +: DW], e1);
          // probe resulting state from port 1
          cycle(OP_IDLE, OP_RD);
          check(tg, rdata_o[DW +: DW], {7'd0, nxt});
          check("R9", rdata_o[0 +: DW], 8'h00);
        end
      end
    end
    // R3: repeated reads while held stay busy on both ports
    cycle(OP_RD, OP_IDLE);
    cycle(OP_IDLE, OP_RD);
    check("R3", rdata_o[DW +: DW], 8'h01);
    cycle(OP_RD, OP_IDLE);
    check("R3", rdata_o[0 +: DW], 8'h01);
    idle_all();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule